// File: doc/BRIEF.md
# Timing Event Fan-out Concentrator

This block sits between one upstream port that faces a timing generator and eight downstream ports that face timing receivers. Every port uses a plain per-cycle parallel interface: an event byte, a distributed-bus byte and a valid bit. In the forward direction, the upstream event and bus bytes are registered once and then broadcast unchanged to every downstream transmit output.

In the backward direction, each downstream port can send event codes towards the generator. A non-null event is written into a 16-entry queue for its port. A round-robin arbiter then drains the non-empty queues onto the single upstream transmit stream, one event per cycle at most. A code that arrives while its queue is full is dropped, and a sticky per-port overflow flag records the loss until software-side logic clears it.

The eight backward bus bytes are merged by a bitwise OR, with a register on the result. A port contributes to this OR only while its receive-valid bit is high and its enable bit is set. The enable mask also keeps a disabled port's events out of its queue.

Top module: `evt_fanout_concentrator`

## Requirements
- R1: One clock edge after `up_rx_evt`, `up_rx_bus` and `up_rx_vld` are sampled, the same values appear on every one of the eight lanes of `dn_tx_evt`, `dn_tx_bus` and `dn_tx_vld`. Lane i occupies bits [8i+7:8i] of a flat bus.
- R2: The event code 0x00 means "no event". It is never queued, and `up_tx_evt` carries 0x00 in every cycle in which no queued event is forwarded.
- R3: A non-null event sampled on port i (with `dn_rx_vld[i]` and `port_en[i]` both high) is stored in that port's 16-entry queue. Events from one port leave upstream in arrival order. An event sampled at edge k can appear on `up_tx_evt` after edge k+1 at the earliest.
- R4: Arbitration is round-robin. At each edge the grant goes to the first non-empty queue found at or after the pointer, searching in ascending index order with wrap-around. After port g is granted, the pointer moves to g+1 (modulo 8). The pointer does not move when nothing is granted.
- R5: At most one event is forwarded upstream per cycle.
- R6: If a write arrives at an edge where port i's queue already holds 16 entries, the event is dropped, even if the same queue is read at that edge. `ovf_flag[i]` is high after that edge and stays high.
- R7: `ovf_clr[i]` clears `ovf_flag[i]` at the next edge, unless a drop on port i occurs at that same edge, in which case the flag stays set.
- R8: `up_tx_bus` is the registered bitwise OR of the bus bytes from ports that have both valid and enable high, with one edge of latency. A port whose valid bit is low contributes nothing.
- R9: A port with `port_en[i]` low queues no events and is left out of the bus OR. Entries it queued earlier still drain.
- R10: Synchronous reset empties all queues and clears the overflow flags and the arbitration pointer. It drives 0x00 events, zero bus bytes and low valid bits on all outputs. After reset, `up_tx_vld` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_rx_evt | input | 8 | Event byte from the upstream port |
| up_rx_bus | input | 8 | Bus byte from the upstream port |
| up_rx_vld | input | 1 | Upstream receive valid |
| dn_tx_evt | output | 64 | Broadcast event bytes, 8 lanes |
| dn_tx_bus | output | 64 | Broadcast bus bytes, 8 lanes |
| dn_tx_vld | output | 8 | Broadcast valid, one bit per lane |
| dn_rx_evt | input | 64 | Backward event bytes from the downstream ports |
| dn_rx_bus | input | 64 | Backward bus bytes from the downstream ports |
| dn_rx_vld | input | 8 | Backward receive valid, per port |
| port_en | input | 8 | Per-port enable mask |
| ovf_clr | input | 8 | Per-port overflow flag clear |
| up_tx_evt | output | 8 | Merged backward event stream |
| up_tx_bus | output | 8 | OR-merged backward bus byte |
| up_tx_vld | output | 1 | Upstream transmit valid |
| ovf_flag | output | 8 | Sticky per-port overflow flags |

## Verification
The hardest situation to reach from the ports is a full queue that is being read at the same edge as a write, combined with a clear request arriving at that edge. It needs more arrivals than drains across several ports for at least 16 cycles. The stimulus makes all eight ports write a non-null code every cycle for dozens of cycles. Each queue then fills while the arbiter drains only one event per cycle. Clears are pulsed during that saturation and again after it, and a long constrained-random phase follows with mixed null codes, valid gaps, enable changes and sparse clears. Every edge is compared against a queue-level model that the bench keeps itself.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t NULL_EVT = 8'h00;
endpackage

// File: rtl/bwd_event_fifo.sv
module bwd_event_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         ovf_clr,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         ovf_flag,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, push;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign push  = wr_req & ~full;
  assign drop  = wr_req & full;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)  wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (drop)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  // R6
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_flag);
  // R7
  clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !drop) |=> !ovf_flag);
  // R3
  no_read_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] gnt_idx,
  output logic         gnt_any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // Search from pointer p upward with wrap; MSB of result flags a hit.
  function automatic logic [IW:0] pick(input logic [N-1:0] r, input logic [IW-1:0] p);
    logic [IW:0] res;
    res = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(p) + k) % N;
      if (r[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  logic [IW-1:0] ptr;
  logic [IW:0]   sel;

  assign sel     = pick(req, ptr);
  assign gnt_any = sel[IW];
  assign gnt_idx = sel[IW-1:0];

  always_comb begin
    grant = '0;
    if (gnt_any) grant[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (gnt_any) ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R4
  grant_only_req_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  // R4
  grant_when_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> gnt_any);
endmodule

// File: rtl/bus_or_merge.sv
module bus_or_merge #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*W-1:0] bus_in,
  input  logic [N-1:0]   keep,
  output logic [W-1:0]   bus_out
);
  function automatic logic [W-1:0] masked_or(input logic [N*W-1:0] b, input logic [N-1:0] m);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++)
      if (m[i]) acc = acc | b[i*W +: W];
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) bus_out <= '0;
    else     bus_out <= masked_or(bus_in, keep);
  end

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (keep == '0) |=> (bus_out == '0));
endmodule

// File: rtl/evt_fanout_concentrator.sv
module evt_fanout_concentrator #(
  parameter int N_PORTS = 8,
  parameter int DEPTH   = 16,
  parameter int W       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         up_rx_evt,
  input  logic [W-1:0]         up_rx_bus,
  input  logic                 up_rx_vld,
  output logic [N_PORTS*W-1:0] dn_tx_evt,
  output logic [N_PORTS*W-1:0] dn_tx_bus,
  output logic [N_PORTS-1:0]   dn_tx_vld,
  input  logic [N_PORTS*W-1:0] dn_rx_evt,
  input  logic [N_PORTS*W-1:0] dn_rx_bus,
  input  logic [N_PORTS-1:0]   dn_rx_vld,
  input  logic [N_PORTS-1:0]   port_en,
  input  logic [N_PORTS-1:0]   ovf_clr,
  output logic [W-1:0]         up_tx_evt,
  output logic [W-1:0]         up_tx_bus,
  output logic                 up_tx_vld,
  output logic [N_PORTS-1:0]   ovf_flag
);
  import fanout_pkg::*;
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [N_PORTS-1:0] live, wr_req, empty, grant, drop;
  logic [W-1:0]       head [N_PORTS];
  logic [IW-1:0]      gnt_idx;
  logic               gnt_any;

  assign live = dn_rx_vld & port_en;

  // Forward broadcast, one register stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_tx_evt <= '0;
      dn_tx_bus <= '0;
      dn_tx_vld <= '0;
    end else begin
      dn_tx_evt <= {N_PORTS{up_rx_evt}};
      dn_tx_bus <= {N_PORTS{up_rx_bus}};
      dn_tx_vld <= {N_PORTS{up_rx_vld}};
    end
  end

  // Backward per-port queues.
  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    assign wr_req[i] = live[i] && (dn_rx_evt[i*W +: W] != W'(NULL_EVT));
    bwd_event_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_req  (wr_req[i]),
      .wr_data (dn_rx_evt[i*W +: W]),
      .rd_en   (grant[i]),
      .ovf_clr (ovf_clr[i]),
      .head    (head[i]),
      .empty   (empty[i]),
      .ovf_flag(ovf_flag[i]),
      .drop    (drop[i])
    );
  end

  rr_arbiter #(.N(N_PORTS)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req    (~empty),
    .grant  (grant),
    .gnt_idx(gnt_idx),
    .gnt_any(gnt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up_tx_evt <= W'(NULL_EVT);
      up_tx_vld <= 1'b0;
    end else begin
      up_tx_evt <= gnt_any ? head[gnt_idx] : W'(NULL_EVT);
      up_tx_vld <= 1'b1;
    end
  end

  bus_or_merge #(.N(N_PORTS), .W(W)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .bus_in (dn_rx_bus),
    .keep   (live),
    .bus_out(up_tx_bus)
  );

  // R1
  fwd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    up_rx_vld |=> (dn_tx_vld == {N_PORTS{1'b1}}));
  // R2
  null_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (empty == {N_PORTS{1'b1}}) |=> (up_tx_evt == W'(NULL_EVT)));
  // R10
  tx_valid_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> up_tx_vld);
endmodule

// File: tb/sim_evt_fanout_concentrator.sv
`timescale 1ns/1ps
module sim_evt_fanout_concentrator;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] up_rx_evt = '0, up_rx_bus = '0;
  logic up_rx_vld = 1'b0;
  logic [NP*8-1:0] dn_tx_evt, dn_tx_bus;
  logic [NP-1:0] dn_tx_vld;
  logic [NP*8-1:0] dn_rx_evt = '0, dn_rx_bus = '0;
  logic [NP-1:0] dn_rx_vld = '0, port_en = '1, ovf_clr = '0;
  logic [7:0] up_tx_evt, up_tx_bus;
  logic up_tx_vld;
  logic [NP-1:0] ovf_flag;

  evt_fanout_concentrator u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string ph = "";

  // Bench model of the queues.
  logic [7:0] mq [NP][16];
  int mh [NP], mc [NP];
  int mptr;
  logic [NP-1:0] m_ovf;
  logic [7:0] e_evt, e_bus;
  logic e_vld;
  logic [NP*8-1:0] e_dn_evt, e_dn_bus;
  logic [NP-1:0] e_dn_vld;

  function automatic logic [7:0] or_of_live(input logic [NP*8-1:0] b, input logic [NP-1:0] v, input logic [NP-1:0] en);
    logic [7:0] a = '0;
    for (int i = 0; i < NP; i++) if (v[i] && en[i]) a |= b[i*8 +: 8];
    return a;
  endfunction

  task automatic model_edge();
    bit full_pre [NP];
    bit found;
    if (rst) begin
      for (int i = 0; i < NP; i++) begin mh[i] = 0; mc[i] = 0; end
      mptr = 0; m_ovf = '0; e_evt = 0; e_bus = 0; e_vld = 0;
      e_dn_evt = '0; e_dn_bus = '0; e_dn_vld = '0;
      return;
    end
    for (int i = 0; i < NP; i++) full_pre[i] = (mc[i] == 16);
    found = 0; e_evt = 8'h00;
    for (int k = 0; k < NP; k++) begin
      int j;
      j = (mptr + k) % NP;
      if (!found && mc[j] > 0) begin
        found = 1;
        e_evt = mq[j][mh[j]];
        mh[j] = (mh[j] + 1) % 16;
        mc[j]--;
        mptr = (j + 1) % NP;
      end
    end
    for (int i = 0; i < NP; i++) begin
      bit dropped;
      dropped = 0;
      if (dn_rx_vld[i] && port_en[i] && dn_rx_evt[i*8 +: 8] != 8'h00) begin
        if (full_pre[i]) dropped = 1;
        else begin
          mq[i][(mh[i] + mc[i]) % 16] = dn_rx_evt[i*8 +: 8];
          mc[i]++;
        end
      end
      if (dropped) m_ovf[i] = 1'b1;
      else if (ovf_clr[i]) m_ovf[i] = 1'b0;
    end
    e_bus = or_of_live(dn_rx_bus, dn_rx_vld, port_en);
    e_vld = 1'b1;
    e_dn_evt = {NP{up_rx_evt}};
    e_dn_bus = {NP{up_rx_bus}};
    e_dn_vld = {NP{up_rx_vld}};
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, ph, act, exp, $time);
    end
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    #1;
    chk(up_tx_evt == e_evt, "R3 R4 R5 up_tx_evt", 64'(up_tx_evt), 64'(e_evt));
    chk(up_tx_bus == e_bus, "R8 up_tx_bus", 64'(up_tx_bus), 64'(e_bus));
    chk(up_tx_vld == e_vld, "R10 up_tx_vld", 64'(up_tx_vld), 64'(e_vld));
    chk(dn_tx_evt == e_dn_evt && dn_tx_bus == e_dn_bus && dn_tx_vld == e_dn_vld,
        "R1 dn_tx", dn_tx_evt, e_dn_evt);
    chk(ovf_flag == m_ovf, "R6 R7 ovf_flag", 64'(ovf_flag), 64'(m_ovf));
  endtask

  task automatic quiet();
    dn_rx_vld = '0; dn_rx_evt = '0; dn_rx_bus = '0; ovf_clr = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R10 reset state
    ph = "reset";
    for (int c = 0; c < 4; c++) step();
    chk(up_tx_evt == 8'h00 && up_tx_bus == 8'h00 && dn_tx_vld == '0 && ovf_flag == '0,
        "R10 reset outputs", {up_tx_evt, up_tx_bus, dn_tx_vld, ovf_flag}, 64'h0);
    rst = 1'b0;

    // R1 forward patterns
    ph = "forward";
    foreach (up_rx_evt[b]) begin
      up_rx_evt = 8'h1 << b; up_rx_bus = ~(8'h1 << b); up_rx_vld = b[0];
      step();
    end
    up_rx_vld = 1'b1;

    // R2 null codes with valid high are never queued
    ph = "null";
    dn_rx_vld = '1; dn_rx_evt = '0;
    for (int c = 0; c < 4; c++) step();
    quiet(); step(); step();
    chk(up_tx_evt == 8'h00, "R2 null never forwarded", 64'(up_tx_evt), 64'h0);

    // R3 single event latency: appears after second edge
    ph = "latency";
    dn_rx_vld[5] = 1'b1; dn_rx_evt[5*8 +: 8] = 8'hA5;
    step();
    quiet();
    chk(up_tx_evt == 8'h00, "R3 not yet forwarded", 64'(up_tx_evt), 64'h0);
    step();
    chk(up_tx_evt == 8'hA5, "R3 forwarded after two edges", 64'(up_tx_evt), 64'hA5);

    // R4 simultaneous arrivals leave in rotating order
    ph = "rr";
    dn_rx_vld = '1;
    for (int i = 0; i < NP; i++) dn_rx_evt[i*8 +: 8] = 8'(8'h10 + i);
    step();
    quiet();
    for (int c = 0; c < NP + 2; c++) step();

    // R6 R7 saturation: all ports write every cycle
    ph = "saturate";
    dn_rx_vld = '1;
    for (int c = 0; c < 60; c++) begin
      for (int i = 0; i < NP; i++) dn_rx_evt[i*8 +: 8] = 8'(c * 8 + i + 1) | 8'h01;
      ovf_clr = (c == 40) ? 8'h0F : 8'h00;
      step();
    end
    chk(ovf_flag == 8'hFF, "R6 flags stuck after drops", 64'(ovf_flag), 64'hFF);
    quiet();
    for (int c = 0; c < 3; c++) step();
    chk(ovf_flag == 8'hFF, "R6 flags sticky", 64'(ovf_flag), 64'hFF);
    ovf_clr = 8'h55; step(); ovf_clr = '0;
    chk(ovf_flag == 8'hAA, "R7 clear selected ports", 64'(ovf_flag), 64'hAA);
    for (int c = 0; c < 140; c++) step();
    ovf_clr = '1; step(); ovf_clr = '0;

    // R9 disabled ports: no queuing, no bus contribution
    ph = "mask";
    port_en = 8'b1111_0000;
    dn_rx_vld = '1;
    for (int i = 0; i < NP; i++) begin
      dn_rx_evt[i*8 +: 8] = 8'(8'h40 + i);
      dn_rx_bus[i*8 +: 8] = 8'h1 << i;
    end
    step();
    chk(up_tx_bus == 8'hF0, "R9 bus excludes disabled ports", 64'(up_tx_bus), 64'hF0);
    quiet();
    for (int c = 0; c < 6; c++) step();
    port_en = '1;

    // R8 valid low is ignored in the OR
    ph = "busvld";
    dn_rx_bus = '1; dn_rx_vld = 8'b0000_0100;
    step();
    chk(up_tx_bus == 8'hFF, "R8 one valid port", 64'(up_tx_bus), 64'hFF);
    dn_rx_vld = '0; step();
    chk(up_tx_bus == 8'h00, "R8 no valid ports", 64'(up_tx_bus), 64'h0);

    // Constrained random
    ph = "random";
    for (int c = 0; c < 3000; c++) begin
      up_rx_evt = 8'($urandom); up_rx_bus = 8'($urandom); up_rx_vld = 1'($urandom);
      for (int i = 0; i < NP; i++) begin
        dn_rx_evt[i*8 +: 8] = ($urandom % 10 < 3) ? 8'h00 : 8'($urandom);
        dn_rx_bus[i*8 +: 8] = 8'($urandom) & 8'($urandom);
      end
      dn_rx_vld = 8'($urandom) | 8'($urandom);
      port_en = ($urandom % 8 == 0) ? 8'($urandom) : 8'hFF;
      ovf_clr = ($urandom % 16 == 0) ? 8'($urandom) : 8'h00;
      step();
    end

    // R10 mid-run reset
    ph = "rereset";
    dn_rx_vld = '1;
    rst = 1'b1; step(); rst = 1'b0;
    chk(ovf_flag == '0 && up_tx_evt == 8'h00 && up_tx_vld == 1'b0,
        "R10 reset clears", {ovf_flag, up_tx_evt, 7'h0, up_tx_vld}, 64'h0);
    quiet();
    step(); step();
    chk(up_tx_evt == 8'h00, "R10 queues emptied", 64'(up_tx_evt), 64'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule